// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Probe

This block holds a small, fully associative table of address translations that software fills and inspects one command at a time. Each entry covers a pair of adjacent virtual pages (even and odd) that share one virtual page number, one address-space identifier and one page-size mask. Each page of the pair has its own physical frame number, valid flag, dirty flag and cache attribute. The entry is global when both low words handed in at write time have their global bit set.

Software presents the four translation register words (high word, two low words, page mask) and an index word, then issues one of four commands. Write-at-index stores into the slot named by the index word. Write-at-random stores into the slot named by a free-running down counter. Probe searches all slots at once for a match. Read loads the register outputs from the slot named by the index word. The down counter gives the victim for random writes, and a lower bound (the wired count) keeps the low slots out of its range.

Top module: `soft_tlb`

## Requirements
- R1: After reset, `done` is 0, `idx_out`, `hi_out`, `lo0_out`, `lo1_out` and `mask_out` are 0, `rand_out` is 15, and every slot holds all zeros.
- R2: Command code 0 (write at index) stores into slot `idx_in` modulo 16; read (code 3) also selects slot `idx_in` modulo 16, so only index bits 3:0 matter.
- R3: On a write, the valid flag of each page comes from bit 1 of its low word, the dirty flag from bit 2, the cache attribute from bits 5:3 and the frame number from bits 29:6. A read returns each low word rebuilt from these fields at the same positions, with bits 31:30 zero.
- R4: The stored global bit is the AND of bit 0 of both low words. A read returns it in bit 0 of both rebuilt low words.
- R5: A write stores the virtual page number from high word bits 31:13 and the identifier from bits 7:0. A read returns them at the same positions, with bits 12:8 zero.
- R6: A write stores page mask bits 24:13. A read returns them at the same positions, with every other bit zero.
- R7: Probe (code 2) matches a slot when its page number equals `hi_in[31:13]` and the slot is global or its identifier equals `hi_in[7:0]`.
- R8: On a probe hit, `idx_out` becomes the lowest matching slot number with bit 31 clear and every other upper bit zero.
- R9: On a probe miss, `idx_out` becomes `idx_in` with bit 31 forced to 1.
- R10: `rand_out` counts down by one each cycle while it is above `wired_in`. When it is at or below `wired_in`, the next value is 15.
- R11: Write at random (code 1) stores into the slot equal to `rand_out` in the cycle the command is sampled.
- R12: Each command sampled with `cmd_valid` high raises `done` for exactly the next cycle. Only probe changes `idx_out`, and only read changes `hi_out`, `lo0_out`, `lo1_out` and `mask_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 write at index, 1 write at random, 2 probe, 3 read |
| hi_in | input | 32 | High word: page number and identifier |
| lo0_in | input | 32 | Low word for the even page |
| lo1_in | input | 32 | Low word for the odd page |
| mask_in | input | 32 | Page size mask word |
| idx_in | input | 32 | Index word for indexed write, read and probe miss |
| wired_in | input | 4 | Lower bound of the random counter |
| done | output | 1 | Command completed (one cycle) |
| idx_out | output | 32 | Probe result |
| hi_out | output | 32 | Read result, high word |
| lo0_out | output | 32 | Read result, even low word |
| lo1_out | output | 32 | Read result, odd low word |
| mask_out | output | 32 | Read result, page mask |
| rand_out | output | 4 | Current random slot |

## Verification
Every command result, from probe index, read words and slot contents to `done`, appears at the clock edge that samples the command, so it is visible one cycle after the strobe. The bench drives each command on a falling edge and reads the outputs at the next falling edge, after exactly that one edge. The random counter moves on every edge, so the bench samples it on each falling edge and predicts the next value from the previous one and the wired bound. For a random write it notes the counter value on the falling edge before the sampling edge, because that value picks the slot.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;

  typedef enum logic [1:0] {
    OP_WR_IDX = 2'd0,
    OP_WR_RND = 2'd1,
    OP_PROBE  = 2'd2,
    OP_READ   = 2'd3
  } tlb_op_e;

  localparam int VPN_W   = 19;
  localparam int ASID_W  = 8;
  localparam int PFN_W   = 24;
  localparam int CATTR_W = 3;
  localparam int PMASK_W = 12;

  typedef struct packed {
    logic [PFN_W-1:0]   pfn;
    logic [CATTR_W-1:0] cattr;
    logic               dirty;
    logic               valid;
  } page_t;

  typedef struct packed {
    logic [VPN_W-1:0]   vpn;
    logic [ASID_W-1:0]  asid;
    logic               glob;
    logic [PMASK_W-1:0] pmask;
    page_t              even;
    page_t              odd;
  } slot_t;

  function automatic page_t unpack_page(input logic [31:0] w);
    page_t p;
    p.valid = w[1];
    p.dirty = w[2];
    p.cattr = w[5:3];
    p.pfn   = w[29:6];
    return p;
  endfunction

  function automatic logic [31:0] pack_page(input page_t p, input logic g);
    return {2'b00, p.pfn, p.cattr, p.dirty, p.valid, g};
  endfunction

  function automatic slot_t build_slot(input logic [31:0] hi, input logic [31:0] lo0,
                                       input logic [31:0] lo1, input logic [31:0] pm);
    slot_t s;
    s.vpn   = hi[31:13];
    s.asid  = hi[7:0];
    s.glob  = lo0[0] & lo1[0];
    s.pmask = pm[24:13];
    s.even  = unpack_page(lo0);
    s.odd   = unpack_page(lo1);
    return s;
  endfunction

endpackage

// File: rtl/soft_tlb_store.sv
module soft_tlb_store
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        waddr,
  input  slot_t                   wdata,
  output slot_t [ENTRIES-1:0]     slots
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slots[i] <= '0;
      end else if (we && (waddr == IDX_W'(i))) begin
        slots[i] <= wdata;
      end
    end
  end

endmodule

// File: rtl/soft_tlb_probe.sv
module soft_tlb_probe
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  slot_t [ENTRIES-1:0] slots,
  input  logic [VPN_W-1:0]    key_vpn,
  input  logic [ASID_W-1:0]   key_asid,
  output logic                hit,
  output logic [IDX_W-1:0]    hit_idx
);

  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = (slots[i].vpn == key_vpn) &&
                      (slots[i].glob || (slots[i].asid == key_asid));
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/soft_tlb_random.sv
module soft_tlb_random #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] wired,
  output logic [IDX_W-1:0] rnd
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd <= TOP;
    end else if (rnd <= wired) begin
      rnd <= TOP;
    end else begin
      rnd <= rnd - 1'b1;
    end
  end

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int PAD_W = 32 - IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [31:0]      hi_in,
  input  logic [31:0]      lo0_in,
  input  logic [31:0]      lo1_in,
  input  logic [31:0]      mask_in,
  input  logic [31:0]      idx_in,
  input  logic [IDX_W-1:0] wired_in,
  output logic             done,
  output logic [31:0]      idx_out,
  output logic [31:0]      hi_out,
  output logic [31:0]      lo0_out,
  output logic [31:0]      lo1_out,
  output logic [31:0]      mask_out,
  output logic [IDX_W-1:0] rand_out
);

  tlb_op_e              op;
  slot_t [ENTRIES-1:0]  slots;
  slot_t                wslot;
  slot_t                rslot;
  logic                 we;
  logic [IDX_W-1:0]     waddr;
  logic [IDX_W-1:0]     sel_idx;
  logic                 hit;
  logic [IDX_W-1:0]     hit_idx;

  assign op      = tlb_op_e'(cmd_op);
  assign sel_idx = idx_in[IDX_W-1:0];
  assign we      = cmd_valid && ((op == OP_WR_IDX) || (op == OP_WR_RND));
  assign waddr   = (op == OP_WR_RND) ? rand_out : sel_idx;
  assign wslot   = build_slot(hi_in, lo0_in, lo1_in, mask_in);
  assign rslot   = slots[sel_idx];

  soft_tlb_random #(.ENTRIES(ENTRIES)) u_rand (
    .clk   (clk),
    .rst   (rst),
    .wired (wired_in),
    .rnd   (rand_out)
  );

  soft_tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .waddr (waddr),
    .wdata (wslot),
    .slots (slots)
  );

  soft_tlb_probe #(.ENTRIES(ENTRIES)) u_probe (
    .slots    (slots),
    .key_vpn  (hi_in[31:13]),
    .key_asid (hi_in[7:0]),
    .hit      (hit),
    .hit_idx  (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      idx_out  <= '0;
      hi_out   <= '0;
      lo0_out  <= '0;
      lo1_out  <= '0;
      mask_out <= '0;
    end else begin
      done <= cmd_valid;
      if (cmd_valid && (op == OP_PROBE)) begin
        idx_out <= hit ? {{PAD_W{1'b0}}, hit_idx} : {1'b1, idx_in[30:0]};
      end
      if (cmd_valid && (op == OP_READ)) begin
        hi_out   <= {rslot.vpn, 5'b00000, rslot.asid};
        lo0_out  <= pack_page(rslot.even, rslot.glob);
        lo1_out  <= pack_page(rslot.odd, rslot.glob);
        mask_out <= {7'b0000000, rslot.pmask, 13'b0};
      end
    end
  end

endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [31:0]      idx_in,
  input logic [IDX_W-1:0] wired_in,
  input logic             done,
  input logic [31:0]      idx_out,
  input logic [31:0]      hi_out,
  input logic [31:0]      lo0_out,
  input logic [31:0]      mask_out,
  input logic [IDX_W-1:0] rand_out
);

  assert_done_follows_R12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> done);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !done);

  assert_rand_step_R10: assert property (@(posedge clk) disable iff (rst)
    (rand_out > wired_in) |=> (rand_out == $past(rand_out) - 1'b1));

  assert_rand_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (rand_out <= wired_in) |=> (rand_out == IDX_W'(ENTRIES - 1)));

  assert_probe_miss_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2) |=>
      (idx_out[31] ? (idx_out[30:0] == $past(idx_in[30:0])) : (idx_out < 32'(ENTRIES))));

  assert_read_zero_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3) |=>
      (hi_out[12:8] == 5'd0 && lo0_out[31:30] == 2'd0 &&
       mask_out[31:25] == 7'd0 && mask_out[12:0] == 13'd0));

  assert_idx_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op != 2'd2) |=> $stable(idx_out));

endmodule

bind soft_tlb soft_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .idx_in    (idx_in),
  .wired_in  (wired_in),
  .done      (done),
  .idx_out   (idx_out),
  .hi_out    (hi_out),
  .lo0_out   (lo0_out),
  .mask_out  (mask_out),
  .rand_out  (rand_out)
);

// File: tb/soft_tlb_tb.sv
`timescale 1ns/1ps
module soft_tlb_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] hi_in = '0, lo0_in = '0, lo1_in = '0, mask_in = '0, idx_in = '0;
  logic [3:0]  wired_in = 4'd0;
  logic        done;
  logic [31:0] idx_out, hi_out, lo0_out, lo1_out, mask_out;
  logic [3:0]  rand_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  soft_tlb u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .hi_in(hi_in), .lo0_in(lo0_in), .lo1_in(lo1_in), .mask_in(mask_in),
    .idx_in(idx_in), .wired_in(wired_in), .done(done), .idx_out(idx_out),
    .hi_out(hi_out), .lo0_out(lo0_out), .lo1_out(lo1_out),
    .mask_out(mask_out), .rand_out(rand_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, result is sampled after one rising edge.
  task automatic issue(input logic [1:0] op, input logic [31:0] hi, input logic [31:0] l0,
                       input logic [31:0] l1, input logic [31:0] pm, input logic [31:0] ix);
    cmd_op = op; hi_in = hi; lo0_in = l0; lo1_in = l1; mask_in = pm; idx_in = ix;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R12 done", {31'd0, done}, 32'd1);
  endtask

  function automatic logic [31:0] exp_lo(input logic [31:0] l, input logic g);
    return (l & 32'h3FFF_FFFE) | {31'd0, g};
  endfunction

  task automatic t_reset;
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 idx_out", idx_out, 32'd0);
    check("R1 hi_out", hi_out, 32'd0);
    check("R1 lo0_out", lo0_out, 32'd0);
    check("R1 mask_out", mask_out, 32'd0);
    check("R1 rand_out", {28'd0, rand_out}, 32'd15);
    issue(2'd3, 32'd0, 32'd0, 32'd0, 32'd0, 32'd9);
    check("R1 slot empty", lo1_out, 32'd0);
  endtask

  task automatic t_write_read;
    logic [31:0] h, a, b, m;
    h = 32'h1234_5F2A; a = 32'hC000_0FFF; b = 32'h1234_5678; m = 32'hFFFF_FFFF;
    issue(2'd0, h, a, b, m, 32'd5);
    issue(2'd3, 32'd0, 32'd0, 32'd0, 32'd0, 32'd5);
    check("R5 hi read", hi_out, h & 32'hFFFF_E0FF);
    check("R3 R4 lo0 read", lo0_out, exp_lo(a, 1'b0));
    check("R3 R4 lo1 read", lo1_out, exp_lo(b, 1'b0));
    check("R6 mask read", mask_out, m & 32'h01FF_E000);
    h = 32'h8765_4033; a = 32'h0000_0043; b = 32'h2AAA_AAA5; m = 32'h0000_6000;
    issue(2'd0, h, a, b, m, 32'h0000_0023);
    issue(2'd3, 32'd0, 32'd0, 32'd0, 32'd0, 32'h0000_0013);
    check("R2 modulo hi", hi_out, h & 32'hFFFF_E0FF);
    check("R4 global lo0", lo0_out, exp_lo(a, 1'b1));
    check("R4 global lo1", lo1_out, exp_lo(b, 1'b1));
    check("R6 mask small", mask_out, 32'h0000_6000);
  endtask

  task automatic t_probe;
    issue(2'd0, 32'h1234_402A, 32'h0000_0006, 32'h0000_0002, 32'd0, 32'd9);
    issue(2'd2, 32'h1234_402A, 32'd0, 32'd0, 32'd0, 32'd0);
    check("R8 lowest hit", idx_out, 32'd5);
    issue(2'd2, 32'h1234_402B, 32'd0, 32'd0, 32'd0, 32'd7);
    check("R9 miss asid", idx_out, 32'h8000_0007);
    issue(2'd2, 32'h8765_4099, 32'd0, 32'd0, 32'd0, 32'd0);
    check("R7 global hit", idx_out, 32'd3);
    check("R12 probe keeps hi_out", hi_out, 32'h8765_4033);
    issue(2'd3, 32'd0, 32'd0, 32'd0, 32'd0, 32'd5);
    check("R12 read keeps idx_out", idx_out, 32'd3);
    @(negedge clk);
    check("R12 done one cycle", {31'd0, done}, 32'd0);
    issue(2'd2, 32'hFFFF_E001, 32'd0, 32'd0, 32'd0, 32'h4000_0001);
    check("R9 miss vpn", idx_out, 32'hC000_0001);
  endtask

  task automatic t_random;
    logic [3:0] prev, exp, r;
    wired_in = 4'd12;
    prev = rand_out;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      exp = (prev <= wired_in) ? 4'd15 : prev - 4'd1;
      check("R10 sequence", {28'd0, rand_out}, {28'd0, exp});
      prev = rand_out;
    end
    wired_in = 4'd15;
    @(negedge clk);
    @(negedge clk);
    check("R10 wired top holds", {28'd0, rand_out}, 32'd15);
    wired_in = 4'd0;
    repeat (3) @(negedge clk);
    r = rand_out;
    issue(2'd1, 32'hFEDC_0011, 32'd0, 32'd0, 32'd0, 32'd0);
    issue(2'd3, 32'd0, 32'd0, 32'd0, 32'd0, {28'd0, r});
    check("R11 random slot", hi_out, 32'hFEDC_0011);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_probe();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule